// File: doc/BRIEF.md
# Error-Tagged Receive FIFO

This block is the receive queue behind a UART-style host interface. Every stored character carries, beside its eight data bits, three flags describing how that character arrived: parity error, framing error and break. An internal controller that delivers characters works in two steps: it first loads the three flags into a shadow register, and then writes the data byte. At the data write the shadow contents are bound to the character and stored with it in an 11-bit entry.

When the host pops a character, the data appears on the read port and the flags stored with that character move into the line status bits 2 to 4, so the host always sees the error status of the character it has just taken. Line status bit 0 reports that data is waiting, and bit 1 reports that a character was lost because the queue was full. The block also reports occupancy, full and empty. Serial framing and the host register decode sit outside it.

Top module: `err_tag_rx_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty: `empty`=1, `full`=0, `level`=0, `lsr`=0 and `rd_data`=0.
- R2: Characters leave in the order they were written, each popped byte equal to the byte written, visible on `rd_data` in the cycle after the clock edge that samples `rd_en`.
- R3: A data write stores the shadow flags held at that clock edge with the character; the flag input order is `flag_in[0]`=parity error, `flag_in[1]`=framing error, `flag_in[2]`=break.
- R4: The shadow flags keep their value across any number of data writes until `flag_ld` loads them again.
- R5: On a pop, `lsr[2]`, `lsr[3]` and `lsr[4]` take the parity, framing and break flags of the popped character, in the same cycle as `rd_data`, and hold them until the next successful pop.
- R6: `lsr[0]` (data waiting) is 1 exactly when `level` is nonzero.
- R7: `level` counts stored characters from 0 to DEPTH (16 by default); `full` is 1 at DEPTH, `empty` is 1 at 0, and the pointers wrap so the queue can be refilled indefinitely.
- R8: A write while full with no read in the same cycle is dropped: stored contents and `level` are unchanged and `lsr[1]` (overrun) becomes 1 and stays 1 until reset.
- R9: A read while empty changes nothing: `rd_data`, `lsr[4:2]` and `level` keep their values.
- R10: A read and a write in the same cycle while full both take effect; `level` stays at DEPTH and no overrun is flagged by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_ld | input | 1 | Load the shadow flag register from `flag_in` |
| flag_in | input | 3 | Flags for the next character: bit0 parity, bit1 framing, bit2 break |
| wr_en | input | 1 | Write `wr_data` with the shadow flags into the queue |
| wr_data | input | 8 | Character to store |
| rd_en | input | 1 | Pop the oldest character |
| rd_data | output | 8 | Last popped character |
| lsr | output | 5 | Line status: bit0 data waiting, bit1 overrun, bits 2-4 flags of last popped character |
| level | output | 5 | Number of stored characters |
| full | output | 1 | Queue holds DEPTH characters |
| empty | output | 1 | Queue holds no characters |

## Verification
The bench builds the block with its defaults, eight data bits and a depth of sixteen, so filling the queue completely takes only sixteen writes and the full boundary, the dropped write with overrun, the read-plus-write at full and the pointer wrap all fall inside a short directed run. A table of characters with distinct flag patterns checks the binding of each flag to its own character and its later appearance in the status bits. Directed cases cover a shadow value reused across several writes and a read from an empty queue.

// File: rtl/err_tag_rx_fifo_pkg.sv
package err_tag_rx_fifo_pkg;
  localparam int FLAG_W = 3;

  // Per-character flag set, bit 0 parity, bit 1 framing, bit 2 break
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } char_flags_t;

  // Line status bit positions
  localparam int LSR_W       = 5;
  localparam int LSR_READY   = 0;
  localparam int LSR_OVERRUN = 1;
  localparam int LSR_FLAG_LO = 2;
endpackage

// File: rtl/rxf_shadow.sv
module rxf_shadow
  import err_tag_rx_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  char_flags_t flags_in,
  output char_flags_t flags_q
);
  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '0;
    else if (load) flags_q <= flags_in;
  end

  // R4: value is held while no load occurs
  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(flags_q));
endmodule

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first output register; holds when no read
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          overrun
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assign rd_ok = rd_req && (count != '0);
  assign wr_ok = wr_req && ((count != FULL) || rd_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_req && !wr_ok) overrun <= 1'b1;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && wr_req && !rd_req) |=> (count == FULL) && overrun);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_full_rdwr_R10: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && wr_req && rd_req) |=> (count == FULL) && $stable(overrun));
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd_req && !wr_req) |=> (count == '0));
endmodule

// File: rtl/err_tag_rx_fifo.sv
module err_tag_rx_fifo
  import err_tag_rx_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int ENT_W = DATA_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LSR_W-1:0]  lsr,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              empty
);
  char_flags_t       shadow_q;
  logic              wr_ok, rd_ok, overrun;
  logic [AW-1:0]     wptr, rptr;
  logic [ENT_W-1:0]  ram_out;

  rxf_shadow u_shadow (
    .clk      (clk),
    .rst      (rst),
    .load     (flag_ld),
    .flags_in (char_flags_t'(flag_in)),
    .flags_q  (shadow_q)
  );

  rxf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_en),
    .rd_req  (rd_en),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .wptr    (wptr),
    .rptr    (rptr),
    .count   (level),
    .overrun (overrun)
  );

  // Entry layout: flags in the top FLAG_W bits, character below
  rxf_ram #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ok),
    .waddr (wptr),
    .wdata ({shadow_q, wr_data}),
    .re    (rd_ok),
    .raddr (rptr),
    .rdata (ram_out)
  );

  assign rd_data = ram_out[DATA_W-1:0];
  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign lsr[LSR_READY]                     = !empty;
  assign lsr[LSR_OVERRUN]                   = overrun;
  assign lsr[LSR_FLAG_LO+FLAG_W-1:LSR_FLAG_LO] = ram_out[ENT_W-1:DATA_W];

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data) && $stable(lsr[4:2]));
  assert_ready_after_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> lsr[LSR_READY]);
  assert_full_empty_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: tb/err_tag_rx_fifo_tb.sv
module err_tag_rx_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flag_ld = 1'b0;
  logic [2:0] flag_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] lsr;
  logic [4:0] level;
  logic       full, empty;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  err_tag_rx_fifo u_dut (
    .clk(clk), .rst(rst), .flag_ld(flag_ld), .flag_in(flag_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .lsr(lsr), .level(level), .full(full), .empty(empty)
  );

  // {flags[2:0], data[7:0]}; flags bit0 parity, bit1 framing, bit2 break
  localparam logic [10:0] VEC [0:7] = '{
    11'h0_3C, 11'h1_A5, 11'h2_5A, 11'h4_FF,
    11'h3_00, 11'h6_81, 11'h5_7E, 11'h7_C3
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_flags(input logic [2:0] f);
    @(negedge clk); flag_ld = 1'b1; flag_in = f;
    @(negedge clk); flag_ld = 1'b0;
  endtask

  // Write with the shadow as it stands; returns at a negedge after the edge
  task automatic write_only(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 lsr", int'(lsr), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // Table walk: push each with its own flags, then pop in order
    for (int i = 0; i < 8; i++) begin
      load_flags(VEC[i][10:8]);
      write_only(VEC[i][7:0]);
      chk("R7 level rising", int'(level), i + 1);
      chk("R6 ready", int'(lsr[0]), 1);
    end
    for (int i = 0; i < 8; i++) begin
      pop();
      chk("R2 order data", int'(rd_data), int'(VEC[i][7:0]));
      chk("R3 R5 flags to lsr", int'(lsr[4:2]), int'(VEC[i][10:8]));
      chk("R7 level falling", int'(level), 7 - i);
    end
    chk("R6 ready low when empty", int'(lsr[0]), 0);

    // R4: one shadow load reused for two writes
    load_flags(3'b101);
    write_only(8'h11);
    write_only(8'h22);
    pop();
    chk("R4 first flags", int'(lsr[4:2]), 5);
    pop();
    chk("R4 second flags", int'(lsr[4:2]), 5);
    chk("R4 second data", int'(rd_data), 8'h22);

    // R7 fill to full (pointers start mid-array, so wrap occurs)
    load_flags(3'b010);
    for (int i = 0; i < 16; i++) write_only(8'(i));
    chk("R7 full", int'(full), 1);
    chk("R7 level 16", int'(level), 16);
    chk("R8 no overrun yet", int'(lsr[1]), 0);

    // R8 write while full is dropped
    write_only(8'hEE);
    chk("R8 level unchanged", int'(level), 16);
    chk("R8 overrun set", int'(lsr[1]), 1);

    // R10 read and write together while full
    rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 level stays full", int'(level), 16);
    chk("R10 popped head", int'(rd_data), 0);

    // Drain: 1..15 then 0x77; 0xEE must not appear
    for (int i = 1; i < 16; i++) begin
      pop();
      chk("R2 R8 drain data", int'(rd_data), i);
    end
    pop();
    chk("R10 pushed data", int'(rd_data), 8'h77);
    chk("R5 drained flags", int'(lsr[4:2]), 2);
    chk("R7 empty after drain", int'(empty), 1);
    chk("R8 overrun sticky", int'(lsr[1]), 1);

    // R9 read while empty
    pop();
    chk("R9 rd_data held", int'(rd_data), 8'h77);
    chk("R9 flags held", int'(lsr[4:2]), 2);
    chk("R9 level held", int'(level), 0);

    // R1 reset clears overrun and status
    do_reset();
    @(negedge clk);
    chk("R1 lsr after reset", int'(lsr), 0);
    chk("R1 level after reset", int'(level), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule